// File: doc/BRIEF.md
# Talker Source Handshake with Selectable Settling Delay

This block is the sending half of a three-wire byte handshake on an 8-bit instrument bus. The host loads a byte through a write strobe. While the block is allowed to send, it places the byte on the data lines and waits out a settling interval of 6 or 11 clocks. It then raises data-valid once the listeners report ready, and drops data-valid once they report the byte accepted. A byte-out flag tells the host when the next byte may be loaded.

Two sources may send. As active controller, the block sends bytes as commands while attention is asserted by this side. As talker, it sends data only while attention is false. A talker byte that is loaded while another controller holds attention waits and goes out after attention is released. A cancel pulse can discard such a waiting byte. A force-end pulse marks only the next data byte with the end line. If at the start of a transfer neither ready nor accept is held back by any listener, the byte is dropped and an error flag is raised.

Top module: `gpib_src_hs`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is applied and in the cycle after it, `dio_out` is 0 and `dav_out`, `eoi_out`, `bo_flag` and `err_flag` are all 0.
- R2: `bo_flag` becomes 1 on the clock edge where `talk_act` or `ctrl_act` is first seen high. It becomes 0 on the edge where the host write is accepted.
- R3: When a write is accepted at edge W and sending is allowed, `dio_out` takes the byte at edge W+1 and `dav_out` rises at edge W+1+T. T is 6 when `short_t1`=1 and 11 when `short_t1`=0. `dio_out` does not change while `dav_out` is 1.
- R4: `dav_out` does not rise while `nrfd_in`=1 (1 = listener not ready). If the settling time has already passed, it rises on the first edge where `nrfd_in`=0.
- R5: `dav_out` stays 1 while `ndac_in`=1 (1 = not yet accepted). It falls on the first edge with `ndac_in`=0, and `bo_flag` becomes 1 on that same edge.
- R6: A host write made while a byte is still pending (`bo_flag`=0) is ignored.
- R7: After a `feoi_pls` pulse, `eoi_out` is 1 together with the next data byte sent as talker, and 0 once that byte completes. Later bytes carry `eoi_out`=0. Command bytes sent with `ctrl_act`=1 never raise `eoi_out`.
- R8: With `talk_act`=1, `ctrl_act`=0 and `atn_in`=1, a loaded byte is not sent. After `atn_in` returns to 0, the full settling time is counted again from the release edge before `dav_out` rises.
- R9: With `ctrl_act`=1, bytes are sent with the same timing whatever the level of `atn_in`.
- R10: A `nbaf_pls` pulse while a byte is pending and `dav_out` is 0 discards the byte. `dav_out` never rises for it, and `bo_flag` becomes 1.
- R11: If a transfer would start while `nrfd_in`=0 and `ndac_in`=0, `err_flag` becomes 1, the byte is discarded and `bo_flag` becomes 1. `err_flag` returns to 0 at the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host write strobe for the outgoing byte |
| wr_byte | input | 8 | Byte written by the host |
| talk_act | input | 1 | Talker active: send data bytes |
| ctrl_act | input | 1 | Controller active: send command bytes |
| atn_in | input | 1 | Attention line as driven by another controller |
| nrfd_in | input | 1 | Not-ready-for-data line, 1 = asserted |
| ndac_in | input | 1 | Not-data-accepted line, 1 = asserted |
| feoi_pls | input | 1 | Mark the next data byte with end |
| nbaf_pls | input | 1 | Discard a pending unsent byte |
| short_t1 | input | 1 | 1 selects a 6-clock settling time, 0 selects 11 |
| dio_out | output | 8 | Data lines driven |
| dav_out | output | 1 | Data-valid drive |
| eoi_out | output | 1 | End drive |
| bo_flag | output | 1 | Ready for the next host byte |
| err_flag | output | 1 | Incomplete handshake, no listener seen |

## Verification
The main transfer is run with both settling lengths, in talker and controller modes, and with and without a pending end mark. The measured write-to-valid latency separates the 6-clock and 11-clock paths, and the end line separates data bytes from commands. Held-off listeners, with ready or accept withheld, show that valid waits on each line separately. Attention held by another controller, with and without a cancel pulse, separates the deferred send from the discard. Listeners that hold back neither line separate the error path from a normal start.

// File: rtl/gpib_src_pkg.sv
package gpib_src_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SETTLE = 2'd1,
    S_WAIT   = 2'd2
  } src_st_e;
endpackage

// File: rtl/gpib_t1_timer.sv
module gpib_t1_timer #(
  parameter int T1_SHORT = 6,
  parameter int T1_LONG  = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic short_sel,
  output logic expired
);
  localparam int CW = $clog2(T1_LONG + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign lim_m1  = short_sel ? CW'(T1_SHORT - 1) : CW'(T1_LONG - 1);
  assign expired = (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R3: the settling counter saturates and never runs past the long limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(T1_LONG - 1));
endmodule

// File: rtl/gpib_byte_hold.sv
module gpib_byte_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         src_act,
  input  logic         kill,
  input  logic         done,
  output logic [W-1:0] data,
  output logic         pend,
  output logic         bo
);
  logic src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      pend  <= 1'b0;
      bo    <= 1'b0;
      src_q <= 1'b0;
    end else begin
      src_q <= src_act;
      if (wr_stb && !pend) begin
        data <= wr_byte;
        pend <= 1'b1;
        bo   <= 1'b0;
      end else if (pend && (kill || done)) begin
        pend <= 1'b0;
        bo   <= 1'b1;
      end else if (src_act && !src_q && !pend) begin
        bo <= 1'b1;
      end
    end
  end

  // R6: a write that arrives while a byte is pending leaves the held byte alone
  a_r6_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (pend && wr_stb) |=> $stable(data));
endmodule

// File: rtl/gpib_src_fsm.sv
module gpib_src_fsm
  import gpib_src_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pend,
  input  logic [W-1:0] data,
  input  logic         wr_stb,
  input  logic         talk_act,
  input  logic         ctrl_act,
  input  logic         atn_in,
  input  logic         nrfd_in,
  input  logic         ndac_in,
  input  logic         feoi_pls,
  input  logic         nbaf_pls,
  input  logic         t1_exp,
  output logic         t1_clr,
  output logic         kill,
  output logic         done,
  output logic [W-1:0] dio_out,
  output logic         dav_out,
  output logic         eoi_out,
  output logic         err_flag
);
  src_st_e st;
  logic    arm;
  logic    go;
  logic    no_lsn;
  logic    err_start;
  logic    ok_start;

  assign go        = ctrl_act || (talk_act && !atn_in);
  assign no_lsn    = !nrfd_in && !ndac_in;
  assign err_start = (st == S_IDLE) && pend && go && !nbaf_pls && no_lsn;
  assign ok_start  = (st == S_IDLE) && pend && go && !nbaf_pls && !no_lsn;
  assign kill      = nbaf_pls && pend && (st != S_WAIT);
  assign done      = err_start || ((st == S_WAIT) && !ndac_in);
  assign t1_clr    = (st != S_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      dio_out  <= '0;
      dav_out  <= 1'b0;
      eoi_out  <= 1'b0;
      err_flag <= 1'b0;
      arm      <= 1'b0;
    end else begin
      if (feoi_pls) arm <= 1'b1;
      if (wr_stb && !pend) err_flag <= 1'b0;
      case (st)
        S_IDLE: begin
          if (err_start) begin
            err_flag <= 1'b1;
          end else if (ok_start) begin
            st      <= S_SETTLE;
            dio_out <= data;
            eoi_out <= arm && !ctrl_act;
          end
        end
        S_SETTLE: begin
          if (nbaf_pls || !go) begin
            st      <= S_IDLE;
            eoi_out <= 1'b0;
          end else if (t1_exp && !nrfd_in) begin
            dav_out <= 1'b1;
            st      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!ndac_in) begin
            dav_out <= 1'b0;
            eoi_out <= 1'b0;
            st      <= S_IDLE;
            if (eoi_out) arm <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4: valid only rises after listeners reported ready
  a_r4_dav_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(dav_out) |-> $past(!nrfd_in));
  // R5: valid only drops after listeners reported acceptance
  a_r5_dav_until_accept: assert property (@(posedge clk) disable iff (rst)
    $fell(dav_out) |-> $past(!ndac_in));
  // R3: data lines are frozen while valid is asserted
  a_r3_dio_stable: assert property (@(posedge clk) disable iff (rst)
    dav_out |-> $stable(dio_out));
  // R11: the error flag only rises when no listener held either line
  a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(!nrfd_in && !ndac_in));
  // R7: end is never attached to a command byte
  a_r7_eoi_data_only: assert property (@(posedge clk) disable iff (rst)
    $rose(eoi_out) |-> $past(!ctrl_act));
endmodule

// File: rtl/gpib_src_hs.sv
module gpib_src_hs #(
  parameter int W        = 8,
  parameter int T1_SHORT = 6,
  parameter int T1_LONG  = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         talk_act,
  input  logic         ctrl_act,
  input  logic         atn_in,
  input  logic         nrfd_in,
  input  logic         ndac_in,
  input  logic         feoi_pls,
  input  logic         nbaf_pls,
  input  logic         short_t1,
  output logic [W-1:0] dio_out,
  output logic         dav_out,
  output logic         eoi_out,
  output logic         bo_flag,
  output logic         err_flag
);
  logic [W-1:0] hold_data;
  logic         pend;
  logic         kill;
  logic         done;
  logic         t1_clr;
  logic         t1_exp;

  gpib_byte_hold #(.W(W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .src_act (talk_act || ctrl_act),
    .kill    (kill),
    .done    (done),
    .data    (hold_data),
    .pend    (pend),
    .bo      (bo_flag)
  );

  gpib_t1_timer #(.T1_SHORT(T1_SHORT), .T1_LONG(T1_LONG)) u_t1 (
    .clk       (clk),
    .rst       (rst),
    .clr       (t1_clr),
    .short_sel (short_t1),
    .expired   (t1_exp)
  );

  gpib_src_fsm #(.W(W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .data     (hold_data),
    .wr_stb   (wr_stb),
    .talk_act (talk_act),
    .ctrl_act (ctrl_act),
    .atn_in   (atn_in),
    .nrfd_in  (nrfd_in),
    .ndac_in  (ndac_in),
    .feoi_pls (feoi_pls),
    .nbaf_pls (nbaf_pls),
    .t1_exp   (t1_exp),
    .t1_clr   (t1_clr),
    .kill     (kill),
    .done     (done),
    .dio_out  (dio_out),
    .dav_out  (dav_out),
    .eoi_out  (eoi_out),
    .err_flag (err_flag)
  );
endmodule

// File: tb/sim_gpib_src_hs.sv
`timescale 1ns/1ps
module sim_gpib_src_hs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       talk_act = 1'b0, ctrl_act = 1'b0, atn_in = 1'b0;
  logic       nrfd_in = 1'b0, ndac_in = 1'b1;
  logic       feoi_pls = 1'b0, nbaf_pls = 1'b0, short_t1 = 1'b0;
  logic [7:0] dio_out;
  logic       dav_out, eoi_out, bo_flag, err_flag;
  logic       auto_lsn = 1'b0;
  int         n_vec = 0;
  int         n_bad = 0;
  int         wd = 0;

  always #2.5 clk = ~clk;

  gpib_src_hs u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .talk_act(talk_act), .ctrl_act(ctrl_act), .atn_in(atn_in),
    .nrfd_in(nrfd_in), .ndac_in(ndac_in), .feoi_pls(feoi_pls),
    .nbaf_pls(nbaf_pls), .short_t1(short_t1), .dio_out(dio_out),
    .dav_out(dav_out), .eoi_out(eoi_out), .bo_flag(bo_flag),
    .err_flag(err_flag)
  );

  // simple listener: always ready, accepts one cycle after seeing valid
  always @(negedge clk) begin
    if (auto_lsn) begin
      nrfd_in <= 1'b0;
      ndac_in <= !dav_out;
    end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 20000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  typedef struct packed {
    logic       sh;
    logic       ctl;
    logic       fe;
    logic [7:0] b;
    logic [3:0] lat;
    logic       eo;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{1'b1, 1'b0, 1'b0, 8'hA5, 4'd7,  1'b0},
    '{1'b0, 1'b0, 1'b0, 8'h3C, 4'd12, 1'b0},
    '{1'b1, 1'b0, 1'b1, 8'h5A, 4'd7,  1'b1},
    '{1'b0, 1'b0, 1'b0, 8'hFF, 4'd12, 1'b0},
    '{1'b1, 1'b1, 1'b0, 8'h3F, 4'd7,  1'b0},
    '{1'b0, 1'b1, 1'b0, 8'h20, 4'd12, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] b);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_byte = b;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic wait_dav(output int n);
    n = 0;
    while (!dav_out && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_dav_low();
    for (int k = 0; k < 40 && dav_out; k++) @(negedge clk);
  endtask

  initial begin
    int  n;
    bit  saw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dio_out == 8'h00, "R1 dio", dio_out, 0);
    chk({dav_out, eoi_out, bo_flag, err_flag} == 4'b0000, "R1 flags",
        {dav_out, eoi_out, bo_flag, err_flag}, 0);

    // R2 byte-out prompt on becoming talker
    talk_act = 1'b1;
    @(negedge clk);
    chk(bo_flag == 1'b1, "R2 bo on talker entry", bo_flag, 1);

    // R4/R5/R6 held-off listener
    nrfd_in = 1'b1;
    ndac_in = 1'b1;
    short_t1 = 1'b1;
    host_write(8'hC3);
    chk(bo_flag == 1'b0, "R2 bo cleared by write", bo_flag, 0);
    repeat (20) @(negedge clk);
    chk(dav_out == 1'b0, "R4 no valid while not ready", dav_out, 0);
    host_write(8'h77);
    nrfd_in = 1'b0;
    @(negedge clk);
    chk(dav_out == 1'b1, "R4 valid on ready", dav_out, 1);
    chk(dio_out == 8'hC3, "R6 second write ignored", dio_out, 8'hC3);
    repeat (5) @(negedge clk);
    chk(dav_out == 1'b1, "R5 valid held until accept", dav_out, 1);
    ndac_in = 1'b0;
    @(negedge clk);
    chk(dav_out == 1'b0, "R5 valid drops on accept", dav_out, 0);
    chk(bo_flag == 1'b1, "R5 bo after completion", bo_flag, 1);
    ndac_in = 1'b1;
    auto_lsn = 1'b1;
    @(negedge clk);

    // table of main transfers: R3 latency, R7 end marking, R9 commands
    foreach (VT[i]) begin
      @(negedge clk);
      short_t1 = VT[i].sh;
      ctrl_act = VT[i].ctl;
      talk_act = !VT[i].ctl;
      if (VT[i].fe) begin
        feoi_pls = 1'b1;
        @(negedge clk);
        feoi_pls = 1'b0;
      end
      host_write(VT[i].b);
      wait_dav(n);
      chk(n == int'(VT[i].lat), "R3 write-to-valid latency", n, VT[i].lat);
      chk(dio_out == VT[i].b, "R3 data on lines", dio_out, VT[i].b);
      chk(eoi_out == VT[i].eo, "R7 end with byte", eoi_out, VT[i].eo);
      wait_dav_low();
      chk(bo_flag == 1'b1, "R5 bo after byte", bo_flag, 1);
      chk(eoi_out == 1'b0, "R7 end released", eoi_out, 0);
    end

    // R9 controller sends while attention high
    ctrl_act = 1'b1;
    talk_act = 1'b0;
    atn_in = 1'b1;
    short_t1 = 1'b0;
    host_write(8'h41);
    wait_dav(n);
    chk(n == 12, "R9 command sent under attention", n, 12);
    wait_dav_low();

    // R8 talker held by attention, then sent with fresh settling
    ctrl_act = 1'b0;
    talk_act = 1'b1;
    short_t1 = 1'b1;
    host_write(8'h6E);
    repeat (20) @(negedge clk);
    chk(dav_out == 1'b0, "R8 held under attention", dav_out, 0);
    atn_in = 1'b0;
    wait_dav(n);
    chk(n == 7, "R8 latency after attention release", n, 7);
    chk(dio_out == 8'h6E, "R8 held byte sent", dio_out, 8'h6E);
    wait_dav_low();

    // R10 discard a waiting byte
    atn_in = 1'b1;
    host_write(8'h99);
    nbaf_pls = 1'b1;
    @(negedge clk);
    nbaf_pls = 1'b0;
    atn_in = 1'b0;
    saw = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (dav_out) saw = 1'b1;
    end
    chk(saw == 1'b0, "R10 discarded byte never valid", saw, 0);
    chk(bo_flag == 1'b1, "R10 bo after discard", bo_flag, 1);

    // R11 no listeners present
    auto_lsn = 1'b0;
    @(negedge clk);
    nrfd_in = 1'b0;
    ndac_in = 1'b0;
    host_write(8'h12);
    @(negedge clk);
    chk(err_flag == 1'b1, "R11 error raised", err_flag, 1);
    chk(bo_flag == 1'b1, "R11 byte dropped", bo_flag, 1);
    repeat (15) @(negedge clk);
    chk(dav_out == 1'b0, "R11 no valid", dav_out, 0);
    ndac_in = 1'b1;
    host_write(8'h13);
    chk(err_flag == 1'b0, "R11 error cleared by write", err_flag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule